// File: doc/BRIEF.md
# Triggered Sample Capture Buffer with Readout

This block keeps a rolling history of converter samples and freezes it when an event occurs. Eight time-interleaved converter lanes each deliver one 5-bit sample per capture-clock cycle. The block merges the lanes into one time-ordered record. On every capture cycle all eight samples are pushed into a 128-entry shift store, so the store always holds the most recent 16 capture cycles, and older samples drop off the far end.

An event detector drives an active-high hold input. The block synchronizes it into the capture domain and turns it into a sticky frozen state that stops all shifting until reset. The frozen state is then synchronized into a separate, slow read-clock domain. There a 7-bit counter steps through the frozen entries one per read cycle, newest first, and presents each one on a 5-bit output. The counter's least significant bit is brought out as a trigger for external measurement equipment, and the whole record is read in 128 read cycles.

Top module: `trig_capture_store`

## Requirements
- R1: While reset is asserted and after its release, every stored entry is zero, the read counter is zero, `rd_data` is 0 and `rd_trig` is 0.
- R2: On each capture cycle that shifts, lane n is taken from `lane_data[5n+4:5n]`. The eight lanes enter in phase order, lane 0 first, so after the shift entry 0 holds lane 7 and entry 7 holds lane 0 of that cycle.
- R3: Each shift moves every entry 8 places deeper. The store keeps 128 entries (the last 16 shifting cycles), and samples pushed beyond entry 127 are discarded.
- R4: `hold_in` passes through a two-flop synchronizer. Take the first rising capture edge at which `hold_in` is sampled high: that edge and the next two still shift, and no later edge shifts.
- R5: Once frozen, the store stays frozen until reset, even if `hold_in` returns low, and later `lane_data` changes have no effect on the read-out record.
- R6: Until the frozen state has passed a two-flop synchronizer in the read domain, the read counter stays at 0, `rd_trig` stays 0 and `rd_data` is 0.
- R7: Once reading is enabled, `rd_data` shows entry 0 (the newest sample), and each later rising read edge advances to the next deeper entry.
- R8: The read counter wraps from 127 to 0, so the 129th entry presented is entry 0 again.
- R9: `rd_trig` always equals the least significant bit of the read counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk | input | 1 | Capture clock, one beat per set of eight lane samples |
| rd_clk | input | 1 | Slow external read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| lane_data | input | 40 | Eight 5-bit lane samples, lane n in bits [5n+4:5n] |
| hold_in | input | 1 | Active-high event input from the detector |
| rd_data | output | 5 | Entry selected by the read counter, 0 until reading is enabled |
| rd_trig | output | 1 | Least significant bit of the read counter |

## Verification
On every cycle, the assertions check the following: the frozen state never clears, the store never changes while frozen, and the counter sits at zero and the output at 0 until reading is enabled. They also check that each enabled read edge adds exactly one to the counter, modulo 128, and that the frozen state only rises three capture edges after the hold was seen. The bench's scenarios cover what needs an independent record of pushed samples. These are the lane-to-entry ordering, the exact edge on which the last shift lands, the discarding of old samples, the wrap back to the newest entry, and the fact that data arriving after the hold drops never appears in the record.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned SAMPLE_W  = 5;
  localparam int unsigned NUM_LANES = 8;
  localparam int unsigned STORE_DEP = 128;
  localparam int unsigned IDX_W     = $clog2(STORE_DEP);

  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tcs_shift_store.sv
module tcs_shift_store #(
  parameter int unsigned W     = 5,
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [LANES*W-1:0] lanes,
  output logic [DEPTH*W-1:0] store_flat
);
  logic [W-1:0] ent_q [DEPTH];
  logic [W-1:0] ent_d [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      if (gi < LANES) begin : g_head
        // newest lane (highest phase) lands nearest the head
        always_comb begin
          ent_d[gi] = shift_en ? lanes[(LANES-1-gi)*W +: W] : ent_q[gi];
        end
      end else begin : g_body
        always_comb begin
          ent_d[gi] = shift_en ? ent_q[gi-LANES] : ent_q[gi];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q[gi] <= '0;
        else        ent_q[gi] <= ent_d[gi];
      end

      assign store_flat[gi*W +: W] = ent_q[gi];
    end
  endgenerate
endmodule

// File: rtl/tcs_read_ctrl.sv
module tcs_read_ctrl #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [DEPTH*W-1:0]       store_flat,
  output logic [$clog2(DEPTH)-1:0] cnt,
  output logic [W-1:0]             data,
  output logic                     trig
);
  localparam int unsigned CW = $clog2(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (rd_en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the store is static once rd_en is high, so the mux is safe to read
  always_comb begin
    data = rd_en ? store_flat[cnt_q*W +: W] : '0;
  end

  assign cnt  = cnt_q;
  assign trig = cnt_q[0];
endmodule

// File: rtl/trig_capture_store.sv
module trig_capture_store
  import tcs_pkg::*;
#(
  parameter int unsigned W     = SAMPLE_W,
  parameter int unsigned LANES = NUM_LANES,
  parameter int unsigned DEPTH = STORE_DEP
) (
  input  logic               cap_clk,
  input  logic               rd_clk,
  input  logic               rst_n,
  input  logic [LANES*W-1:0] lane_data,
  input  logic               hold_in,
  output logic [W-1:0]       rd_data,
  output logic               rd_trig
);
  localparam int unsigned CW = $clog2(DEPTH);

  logic               cap_rst_n;
  logic               rd_rst_n;
  logic               hold_s;
  logic               frozen;
  logic               frozen_d;
  logic               rd_en;
  logic [DEPTH*W-1:0] store_flat;
  logic [CW-1:0]      rd_cnt;

  tcs_sync #(.STAGES(2)) cap_rst_i (
    .clk(cap_clk), .rst_n(rst_n), .din(1'b1), .dout(cap_rst_n)
  );

  tcs_sync #(.STAGES(2)) rd_rst_i (
    .clk(rd_clk), .rst_n(rst_n), .din(1'b1), .dout(rd_rst_n)
  );

  tcs_sync #(.STAGES(2)) hold_sync_i (
    .clk(cap_clk), .rst_n(cap_rst_n), .din(hold_in), .dout(hold_s)
  );

  // sticky freeze
  always_comb begin
    frozen_d = frozen | hold_s;
  end

  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) frozen <= 1'b0;
    else            frozen <= frozen_d;
  end

  tcs_shift_store #(.W(W), .LANES(LANES), .DEPTH(DEPTH)) store_i (
    .clk(cap_clk), .rst_n(cap_rst_n), .shift_en(~frozen),
    .lanes(lane_data), .store_flat(store_flat)
  );

  tcs_sync #(.STAGES(2)) frz_sync_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .din(frozen), .dout(rd_en)
  );

  tcs_read_ctrl #(.W(W), .DEPTH(DEPTH)) read_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .store_flat(store_flat),
    .cnt(rd_cnt), .data(rd_data), .trig(rd_trig)
  );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 128
) (
  input logic                     cap_clk,
  input logic                     rd_clk,
  input logic                     cap_rst_n,
  input logic                     rd_rst_n,
  input logic                     hold_in,
  input logic                     frozen,
  input logic [DEPTH*W-1:0]       store_flat,
  input logic                     rd_en,
  input logic [$clog2(DEPTH)-1:0] rd_cnt,
  input logic [W-1:0]             rd_data
);
  localparam int unsigned CW = $clog2(DEPTH);

  // R5: frozen never clears without reset
  p_sticky_freeze_r5: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    frozen |=> frozen);

  // R5: no store change while frozen
  p_store_still_r5: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    frozen |=> $stable(store_flat));

  // R4: freeze appears three edges after hold was sampled
  p_hold_latency_r4: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    $rose(frozen) |-> $past(hold_in, 3));

  // R6: idle read side
  p_idle_read_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |-> (rd_cnt == '0 && rd_data == '0));

  // R8: single-step advance with wrap
  p_count_step_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en |=> rd_cnt == CW'($past(rd_cnt) + 1'b1));
endmodule

bind trig_capture_store tcs_checker #(.W(W), .DEPTH(DEPTH)) chk_i (
  .cap_clk(cap_clk), .rd_clk(rd_clk), .cap_rst_n(cap_rst_n), .rd_rst_n(rd_rst_n),
  .hold_in(hold_in), .frozen(frozen), .store_flat(store_flat), .rd_en(rd_en),
  .rd_cnt(rd_cnt), .rd_data(rd_data)
);

// File: tb/trig_capture_store_tb_top.sv
module trig_capture_store_tb_top;
  localparam int W = 5;
  localparam int LANES = 8;
  localparam int DEPTH = 128;

  logic cap_clk = 1'b0;
  logic rd_clk;
  logic rst_n;
  logic [LANES*W-1:0] lane_data;
  logic hold_in;
  logic [W-1:0] rd_data;
  logic rd_trig;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] exp_ent [DEPTH];
  logic m_frozen;
  int   m_hcnt;

  always #2.5 cap_clk = ~cap_clk;

  trig_capture_store dut_i (
    .cap_clk(cap_clk), .rd_clk(rd_clk), .rst_n(rst_n), .lane_data(lane_data),
    .hold_in(hold_in), .rd_data(rd_data), .rd_trig(rd_trig)
  );

  // reference record built from the requirements
  always @(posedge cap_clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) exp_ent[i] = '0;
      m_frozen = 1'b0;
      m_hcnt   = 0;
    end else if (!m_frozen) begin
      for (int i = DEPTH-1; i >= LANES; i--) exp_ent[i] = exp_ent[i-LANES];
      for (int l = 0; l < LANES; l++) exp_ent[LANES-1-l] = lane_data[l*W +: W];
      if (hold_in || m_hcnt > 0) m_hcnt = m_hcnt + 1;
      if (m_hcnt == 3) m_frozen = 1'b1;
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd_pulse();
    rd_clk = 1'b1;
    #5;
  endtask

  task automatic rd_low();
    rd_clk = 1'b0;
    #15;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lane_data = '0; hold_in = 1'b0; rd_clk = 1'b0;
    repeat (3) @(posedge cap_clk);
    @(negedge cap_clk);
    check("R1 rd_data in reset", rd_data, 0);
    check("R1 rd_trig in reset", rd_trig, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge cap_clk);
  endtask

  task automatic push(int cycles, int seed);
    for (int c = 0; c < cycles; c++) begin
      @(negedge cap_clk);
      for (int l = 0; l < LANES; l++)
        lane_data[l*W +: W] = W'((c*LANES + l)*7 + seed);
    end
  endtask

  task automatic idle_reads(int n);
    for (int i = 0; i < n; i++) begin
      rd_pulse();
      check("R6 rd_trig before freeze", rd_trig, 0);
      check("R6 rd_data before freeze", rd_data, 0);
      rd_low();
    end
  endtask

  task automatic readout();
    rd_pulse();
    check("R6 first sync edge", rd_data, 0);
    rd_low();
    for (int k = 0; k < DEPTH; k++) begin
      rd_pulse();
      if (k < 8)          check($sformatf("R2 entry %0d", k), rd_data, exp_ent[k]);
      else if (k < 24)    check($sformatf("R4 entry %0d", k), rd_data, exp_ent[k]);
      else if (k >= 120)  check($sformatf("R3 entry %0d", k), rd_data, exp_ent[k]);
      else                check($sformatf("R7 entry %0d", k), rd_data, exp_ent[k]);
      check($sformatf("R9 trig at %0d", k), rd_trig, k & 1);
      rd_low();
    end
    rd_pulse();
    check("R8 wrap to entry 0", rd_data, exp_ent[0]);
    check("R8 trig after wrap", rd_trig, 0);
    rd_low();
  endtask

  task automatic scen_long_history();
    do_reset();
    idle_reads(3);
    push(20, 3);
    @(negedge cap_clk);
    hold_in = 1'b1;
    for (int l = 0; l < LANES; l++) lane_data[l*W +: W] = W'(l + 20);
    push(3, 11);
    hold_in = 1'b0;
    push(10, 17);
    idle_reads(0);
    readout();
    push(5, 29);
    rd_pulse();
    check("R5 record unchanged after hold drop", rd_data, exp_ent[1]);
    rd_low();
  endtask

  task automatic scen_short_history();
    do_reset();
    idle_reads(2);
    push(3, 5);
    @(negedge cap_clk);
    hold_in = 1'b1;
    push(4, 9);
    readout();
    check("R1 cleared tail entry", exp_ent[DEPTH-1], 0);
  endtask

  initial begin
    rd_clk = 1'b0;
    scen_long_history();
    scen_short_history();
    report();
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule